// File: doc/BRIEF.md
# Compare-Capture Timer Channel Bank

This block holds a free-running system counter and a parameterised bank of compare/capture channels. A start strobe resets the counter to zero, lets it run and raises a sticky counter-valid flag. From then on the counter advances by one on every cycle that the tick enable is high. Each channel holds a compare value the width of the counter, an enable bit and a sticky event flag. While a channel is enabled and its compare value is less than or equal to the counter, the channel fires. Firing sets the event flag and raises a one-cycle publish pulse.

Software reaches the channels through a word-wide write strobe and a read strobe. Read data is registered. The compare value can be written as two words, or moved by an offset relative to the counter or to its own current value. Channel 0 can rearm itself from a shared interval register, which gives a periodic tick. A per-channel capture strobe copies the counter into the compare value and turns the compare function off. This lets the same channel timestamp an external occurrence.

Top module: `tcb_bank`

## Requirements
- R1: After a synchronous active-high reset, all event flags, publish pulses, the counter-valid flag, the counter, every compare value and enable, and the interval read as zero.
- R2: The start strobe loads zero into the counter and sets the counter-valid flag. The counter then advances by one on each cycle with tick enable high. It does not count before the first start. Hardware never clears the valid flag, and a later start keeps it set. The counter reads at global field 0 (bits 31:0) and global field 1 (upper bits, zero-extended).
- R3: An enabled channel fires when compare value <= counter, so a value equal to or already below the counter fires on the first cycle after enabling. A value one above the counter does not fire.
- R4: A write to channel field 0 (low compare word, bits 31:0) clears that channel's enable. A write to field 1 (compare bits above 31, taken from the data LSBs) sets it. Field 3 reads the enable in bit 0 and writes it from bit 0.
- R5: A write to field 2 adds data bits 30:0 to the counter when data bit 31 is 0, or to the channel's compare value when bit 31 is 1. The sum is stored as the new compare value, with carry into the high word, and the channel is enabled.
- R6: A firing channel other than channel 0 clears its own enable and keeps its compare value. Channel 0 does the same when the interval is 0.
- R7: When channel 0 fires and the interval (global field 2, read/write) is nonzero, the interval is added to its compare value and the channel stays enabled, so it fires again later.
- R8: A capture strobe on a channel clears its enable and loads the current counter into its compare value.
- R9: A channel's event flag stays set until software writes field 4 of that channel with data bit 0 equal to 0. Writing 1 there has no effect. The publish pulse is high for the single cycle in which the flag is set by that match.
- R10: Channels that match on the same cycle all set their flags and pulse on that cycle.
- R11: Addresses are {global bit (MSB), channel index, 3-bit field}. A read strobe returns the addressed field on rd_data one cycle later. Channel field 4 reads the event flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start strobe: zero and run the counter |
| tick_en | input | 1 | Count enable for the running counter |
| capture_stb | input | N_CH | Per-channel capture strobes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| cnt_valid | output | 1 | Sticky counter-valid flag |
| cmp_evt | output | N_CH | Sticky per-channel compare event flags |
| cmp_pulse | output | N_CH | One-cycle publish pulse per match |

## Verification
A stale or wrong enable bit shows up as a missing or extra event flag. The flag appears at the ports one cycle after the counter reaches the compare value, or one cycle after the enabling write when the value is already in the past. A corrupted compare value shows as a wrong word on the next read of fields 0 or 1, and as an event that comes early or late. This is most visible after the offset add, after the channel 0 reload and after capture, all of which the bench reads back while the counter is held frozen. A wrong counter or valid state is visible on the next counter read and at the valid pin in the cycle after start.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int WORD_W      = 32;
    localparam int FLD_W       = 3;
    localparam int ADD_REF_BIT = 31;
    localparam int ADD_OFF_W   = 31;

    typedef enum logic [FLD_W-1:0] {
        F_CMP_LO = 3'd0,
        F_CMP_HI = 3'd1,
        F_ADD    = 3'd2,
        F_ENABLE = 3'd3,
        F_EVENT  = 3'd4
    } ch_field_e;

    typedef enum logic [FLD_W-1:0] {
        G_CNT_LO   = 3'd0,
        G_CNT_HI   = 3'd1,
        G_INTERVAL = 3'd2
    } glb_field_e;

    typedef struct packed {
        logic lo;
        logic hi;
        logic add;
        logic en;
        logic evt;
    } ch_cmd_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tcb_counter.sv
module tcb_counter #(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
            valid   <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            running <= 1'b1;
            valid   <= 1'b1;
        end else if (running && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tcb_channel.sv
module tcb_channel
    import tcb_pkg::*;
#(
    parameter int CNT_W  = 52,
    parameter int INT_W  = 32,
    parameter bit RELOAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_cmd_t           cmd,
    input  logic [WORD_W-1:0] wdata,
    input  logic              capture,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [INT_W-1:0]  interval,
    output logic [CNT_W-1:0]  cmp,
    output logic              en,
    output logic              evt,
    output logic              pulse
);
    localparam int HI_W = CNT_W - WORD_W;

    logic             hit;
    logic [CNT_W-1:0] cmp_n;
    logic             en_n;
    logic [CNT_W-1:0] add_base;

    assign hit      = en && (cmp <= cnt);
    assign add_base = wdata[ADD_REF_BIT] ? cmp : cnt;

    always_comb begin
        cmp_n = cmp;
        en_n  = en;
        if (hit) begin
            if (RELOAD && (interval != '0)) cmp_n = cmp + CNT_W'(interval);
            else                            en_n  = 1'b0;
        end
        if (capture) begin
            en_n  = 1'b0;
            cmp_n = cnt;
        end else if (cmd.lo) begin
            cmp_n[WORD_W-1:0] = wdata;
            en_n              = 1'b0;
        end else if (cmd.hi) begin
            cmp_n[CNT_W-1:WORD_W] = wdata[HI_W-1:0];
            en_n                  = 1'b1;
        end else if (cmd.add) begin
            cmp_n = add_base + CNT_W'(wdata[ADD_OFF_W-1:0]);
            en_n  = 1'b1;
        end else if (cmd.en) begin
            en_n = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp   <= '0;
            en    <= 1'b0;
            evt   <= 1'b0;
            pulse <= 1'b0;
        end else begin
            cmp   <= cmp_n;
            en    <= en_n;
            pulse <= hit;
            if (hit)                       evt <= 1'b1;
            else if (cmd.evt && !wdata[0]) evt <= 1'b0;
        end
    end
endmodule

// File: rtl/tcb_rd_mux.sv
module tcb_rd_mux
    import tcb_pkg::*;
#(
    parameter int N_CH   = 12,
    parameter int CNT_W  = 52,
    parameter int INT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [N_CH-1:0][CNT_W-1:0] cmp_all,
    input  logic [N_CH-1:0]            en_all,
    input  logic [N_CH-1:0]            evt_all,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [INT_W-1:0]           interval,
    output logic [WORD_W-1:0]          rd_data
);
    localparam int CH_W = ADDR_W - 1 - FLD_W;
    localparam int HI_W = CNT_W - WORD_W;

    logic              glob;
    logic [CH_W-1:0]   ch;
    logic [FLD_W-1:0]  fld;
    logic [WORD_W-1:0] sel;

    assign glob = rd_addr[ADDR_W-1];
    assign ch   = rd_addr[FLD_W +: CH_W];
    assign fld  = rd_addr[FLD_W-1:0];

    always_comb begin
        sel = '0;
        if (glob) begin
            case (fld)
                G_CNT_LO:   sel = cnt[WORD_W-1:0];
                G_CNT_HI:   sel = WORD_W'(cnt[CNT_W-1:WORD_W]);
                G_INTERVAL: sel = WORD_W'(interval);
                default:    sel = '0;
            endcase
        end else if (int'(ch) < N_CH) begin
            case (fld)
                F_CMP_LO: sel = cmp_all[ch][WORD_W-1:0];
                F_CMP_HI: sel = WORD_W'(cmp_all[ch][CNT_W-1:WORD_W]);
                F_ENABLE: sel = WORD_W'(en_all[ch]);
                F_EVENT:  sel = WORD_W'(evt_all[ch]);
                default:  sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    if (HI_W > WORD_W) begin : g_bad_width
        initial $error("counter high part wider than a word");
    end
endmodule

// File: rtl/tcb_bank.sv
module tcb_bank
    import tcb_pkg::*;
#(
    parameter int N_CH  = 12,
    parameter int CNT_W = 52,
    parameter int INT_W = 32,
    localparam int CH_W   = idx_w(N_CH),
    localparam int ADDR_W = 1 + CH_W + FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              tick_en,
    input  logic [N_CH-1:0]   capture_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              cnt_valid,
    output logic [N_CH-1:0]   cmp_evt,
    output logic [N_CH-1:0]   cmp_pulse
);
    logic [CNT_W-1:0]           cnt_q;
    logic                       running_q;
    logic [INT_W-1:0]           interval_q;
    logic [N_CH-1:0][CNT_W-1:0] cmp_all;
    logic [N_CH-1:0]            en_all;
    ch_cmd_t [N_CH-1:0]         cmds;
    logic [N_CH-1:0]            evt_clr_vec;
    logic [N_CH-1:0]            hi_vec;
    logic [N_CH-1:0]            lo_vec;

    logic             wr_glob;
    logic [CH_W-1:0]  wr_ch;
    logic [FLD_W-1:0] wr_fld;

    assign wr_glob = wr_addr[ADDR_W-1];
    assign wr_ch   = wr_addr[FLD_W +: CH_W];
    assign wr_fld  = wr_addr[FLD_W-1:0];

    tcb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .start   (start_req),
        .tick    (tick_en),
        .cnt     (cnt_q),
        .running (running_q),
        .valid   (cnt_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)
            interval_q <= '0;
        else if (wr_en && wr_glob && (wr_fld == G_INTERVAL))
            interval_q <= wr_data[INT_W-1:0];
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic sel;
        assign sel         = wr_en && !wr_glob && (int'(wr_ch) == i);
        assign cmds[i].lo  = sel && (wr_fld == F_CMP_LO);
        assign cmds[i].hi  = sel && (wr_fld == F_CMP_HI);
        assign cmds[i].add = sel && (wr_fld == F_ADD);
        assign cmds[i].en  = sel && (wr_fld == F_ENABLE);
        assign cmds[i].evt = sel && (wr_fld == F_EVENT);
        assign evt_clr_vec[i] = cmds[i].evt && !wr_data[0];
        assign hi_vec[i]      = cmds[i].hi;
        assign lo_vec[i]      = cmds[i].lo;

        tcb_channel #(
            .CNT_W  (CNT_W),
            .INT_W  (INT_W),
            .RELOAD (i == 0)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmds[i]),
            .wdata    (wr_data),
            .capture  (capture_stb[i]),
            .cnt      (cnt_q),
            .interval (interval_q),
            .cmp      (cmp_all[i]),
            .en       (en_all[i]),
            .evt      (cmp_evt[i]),
            .pulse    (cmp_pulse[i])
        );
    end

    tcb_rd_mux #(
        .N_CH   (N_CH),
        .CNT_W  (CNT_W),
        .INT_W  (INT_W),
        .ADDR_W (ADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .cmp_all  (cmp_all),
        .en_all   (en_all),
        .evt_all  (cmp_evt),
        .cnt      (cnt_q),
        .interval (interval_q),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/tcb_bank_chk.sv
module tcb_bank_chk #(
    parameter int N_CH  = 12,
    parameter int CNT_W = 52
) (
    input logic             clk,
    input logic             rst,
    input logic             start_req,
    input logic             tick_en,
    input logic [CNT_W-1:0] cnt,
    input logic             running,
    input logic             cnt_valid,
    input logic [N_CH-1:0]  cmp_evt,
    input logic [N_CH-1:0]  cmp_pulse,
    input logic [N_CH-1:0]  clr_vec,
    input logic [N_CH-1:0]  hi_vec,
    input logic [N_CH-1:0]  lo_vec,
    input logic [N_CH-1:0]  cap_vec,
    input logic [N_CH-1:0]  en_vec
);
    p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
        start_req |=> (cnt == '0) && cnt_valid);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (running && tick_en && !start_req) |=> cnt == $past(cnt) + 1'b1);

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !start_req) |=> $stable(cnt));

    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_valid |=> cnt_valid);

    p_valid_needs_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_valid && !start_req) |=> !cnt_valid);

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        p_pulse_flag_r9: assert property (@(posedge clk) disable iff (rst)
            cmp_pulse[i] |-> cmp_evt[i]);

        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (cmp_evt[i] && !clr_vec[i]) |=> cmp_evt[i]);

        p_hi_enables_r4: assert property (@(posedge clk) disable iff (rst)
            (hi_vec[i] && !cap_vec[i]) |=> en_vec[i]);

        p_lo_disables_r4: assert property (@(posedge clk) disable iff (rst)
            (lo_vec[i] && !cap_vec[i]) |=> !en_vec[i]);

        p_capture_disables_r8: assert property (@(posedge clk) disable iff (rst)
            cap_vec[i] |=> !en_vec[i]);
    end
endmodule

bind tcb_bank tcb_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .tick_en   (tick_en),
    .cnt       (cnt_q),
    .running   (running_q),
    .cnt_valid (cnt_valid),
    .cmp_evt   (cmp_evt),
    .cmp_pulse (cmp_pulse),
    .clr_vec   (evt_clr_vec),
    .hi_vec    (hi_vec),
    .lo_vec    (lo_vec),
    .cap_vec   (capture_stb),
    .en_vec    (en_all)
);

// File: tb/test_tcb_bank.sv
module test_tcb_bank;
    localparam int N_CH   = 12;
    localparam int CNT_W  = 52;
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int ADDR_W = 1 + CH_W + 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_req = 1'b0;
    logic              tick_en = 1'b0;
    logic [N_CH-1:0]   capture_stb = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              cnt_valid;
    logic [N_CH-1:0]   cmp_evt;
    logic [N_CH-1:0]   cmp_pulse;

    always #2.5 clk = ~clk;

    tcb_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) i_tcb_bank (
        .clk(clk), .rst(rst), .start_req(start_req), .tick_en(tick_en),
        .capture_stb(capture_stb), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_valid(cnt_valid), .cmp_evt(cmp_evt), .cmp_pulse(cmp_pulse)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_en_q = 1'b0;

    always @(posedge clk) rd_en_q <= rd_en;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // monitor: pops expected read results as the design returns them
    always @(negedge clk) begin
        if (rd_en_q && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data, e, t);
        end
    end

    function automatic logic [ADDR_W-1:0] ca(input int c, input int f);
        return ADDR_W'((c << 3) | f);
    endfunction
    function automatic logic [ADDR_W-1:0] ga(input int f);
        return ADDR_W'((1 << (ADDR_W-1)) | f);
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic do_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(32'(cmp_evt), 32'h0, "R1 flags");
        chk(32'(cmp_pulse), 32'h0, "R1 pulses");
        chk(32'(cnt_valid), 32'h0, "R1 valid");
        rd(ca(0, 3), 32'h0, "R1 enable ch0");
        rd(ga(2), 32'h0, "R1 interval");

        // R2 no counting before start
        ticks(3);
        rd(ga(0), 32'd0, "R2 count before start");
        chk(32'(cnt_valid), 32'h0, "R2 valid before start");
        do_start();
        chk(32'(cnt_valid), 32'h1, "R2 valid after start");
        ticks(10);
        rd(ga(0), 32'd10, "R2 count lo");
        rd(ga(1), 32'd0, "R2 count hi");

        // R4 low write clears enable, high write sets it (ch7)
        wr(ca(7, 0), 32'd500);
        wr(ca(7, 1), 32'd0);
        rd(ca(7, 3), 32'd1, "R4 enable after high write");
        wr(ca(7, 0), 32'd600);
        rd(ca(7, 3), 32'd0, "R4 enable after low write");

        // R3 past value fires one cycle after enabling (ch1)
        wr(ca(1, 0), 32'd5);
        wr(ca(1, 1), 32'd0);
        @(negedge clk);
        chk(32'(cmp_pulse[1]), 32'h1, "R3 pulse on past value");
        chk(32'(cmp_evt[1]), 32'h1, "R3 flag on past value");
        @(negedge clk);
        chk(32'(cmp_pulse[1]), 32'h0, "R9 pulse lasts one cycle");
        chk(32'(cmp_evt[1]), 32'h1, "R9 flag sticky");
        rd(ca(1, 3), 32'd0, "R6 enable cleared by match");
        rd(ca(1, 0), 32'd5, "R6 compare kept");
        rd(ca(1, 4), 32'd1, "R11 event field read");

        // R3 boundary: compare one above counter does not fire (ch2, cmp 13)
        wr(ca(2, 0), 32'd13);
        wr(ca(2, 1), 32'd0);
        idle(3);
        chk(32'(cmp_evt[2]), 32'h0, "R3 no fire above counter");
        ticks(2);
        @(negedge clk);
        chk(32'(cmp_evt[2]), 32'h0, "R3 no fire at counter 12");
        ticks(1);
        @(negedge clk);
        chk(32'(cmp_evt[2]), 32'h1, "R3 fire at equal");

        // R9 clear by writing 0; writing 1 has no effect
        wr(ca(1, 4), 32'd0);
        chk(32'(cmp_evt[1]), 32'h0, "R9 flag cleared");
        chk(32'(cmp_evt[2]), 32'h1, "R9 other flag kept");
        wr(ca(2, 4), 32'd1);
        chk(32'(cmp_evt[2]), 32'h1, "R9 write one ignored");

        // R5 offset add (counter frozen at 13)
        wr(ca(3, 2), 32'd100);
        rd(ca(3, 0), 32'd113, "R5 add to counter");
        rd(ca(3, 3), 32'd1, "R5 add enables");
        chk(32'(cmp_evt[3]), 32'h0, "R5 no early fire");
        wr(ca(3, 2), 32'h8000_0007);
        rd(ca(3, 0), 32'd120, "R5 add to compare");
        wr(ca(4, 0), 32'hFFFF_FFF0);
        wr(ca(4, 1), 32'd0);
        wr(ca(4, 2), 32'h8000_0020);
        rd(ca(4, 0), 32'h10, "R5 carry low word");
        rd(ca(4, 1), 32'h1, "R5 carry high word");

        // R8 capture
        capture_stb[3] = 1'b1;
        @(negedge clk);
        capture_stb[3] = 1'b0;
        rd(ca(3, 3), 32'd0, "R8 capture disables");
        rd(ca(3, 0), 32'd13, "R8 captured low");
        rd(ca(3, 1), 32'd0, "R8 captured high");

        // R7 periodic reload on channel 0
        wr(ga(2), 32'd4);
        rd(ga(2), 32'd4, "R7 interval readback");
        wr(ca(0, 0), 32'd15);
        wr(ca(0, 1), 32'd0);
        ticks(2);
        @(negedge clk);
        chk(32'(cmp_evt[0]), 32'h1, "R7 first fire");
        rd(ca(0, 0), 32'd19, "R7 compare advanced");
        rd(ca(0, 3), 32'd1, "R7 stays enabled");
        wr(ca(0, 4), 32'd0);
        ticks(4);
        @(negedge clk);
        chk(32'(cmp_evt[0]), 32'h1, "R7 second fire");
        rd(ca(0, 0), 32'd23, "R7 compare advanced again");

        // R10 simultaneous matches
        wr(ca(0, 3), 32'd0);
        wr(ga(2), 32'd0);
        wr(ca(5, 0), 32'd30);
        wr(ca(5, 1), 32'd0);
        wr(ca(6, 0), 32'd30);
        wr(ca(6, 1), 32'd0);
        ticks(11);
        @(negedge clk);
        chk(32'(cmp_pulse[6:5]), 32'h3, "R10 both pulse together");
        chk(32'(cmp_evt[6:5]), 32'h3, "R10 both flags set");
        rd(ga(0), 32'd30, "R2 count after ticks");

        // R2 restart keeps valid, count returns to zero
        do_start();
        chk(32'(cnt_valid), 32'h1, "R2 valid kept on restart");
        rd(ga(0), 32'd0, "R2 count zero after restart");

        finish_run();
    end
endmodule